// File: doc/BRIEF.md
# First-Error Bus Capture Register

This block sits beside one bus port of a memory controller and keeps a record of the first faulty transaction seen on that port. Detection happens elsewhere: the block receives a read-error event and a write-error event, each with a valid strobe, a 13-bit master ID, an address and three cause flags. The cause flags mark an uncorrectable (double-bit) ECC error, an access to a restricted bank and a write into a ROM region.

When an error arrives while the sticky status bit is clear, the block loads the error-type register and the error-address register on the same clock edge. It then sets the status bit and raises a level interrupt. Later errors leave both registers untouched until software writes a one to the status bit. If a read error and a write error arrive in the same cycle, the write error is kept, so the type and address registers always describe the same transaction.

Software reaches three words through a small register port. A 2-bit index selects the word, and read data is combinational on that index. Index 0 is the status word, where bit 0 is the sticky flag and is cleared by writing one to it. Index 1 is the error-type word and index 2 is the error-address word. Index 3 reads as zero.

Top module: `errCaptureReg`

## Requirements
- R1: After reset the status bit, the error-type word, the error-address word and `errIrq` are all 0.
- R2: An error event seen while the status bit is 0 loads the type word and the address word on the next clock edge. The status bit (status word bit 0) reads 1 from that edge on, and reads 0 before it.
- R3: While the status bit is 1, further error events leave the type word and the address word unchanged.
- R4: A register write of data bit 0 = 1 to index 0 clears the status bit and re-arms capture. A write with data bit 0 = 0 to index 0 leaves the status bit set.
- R5: A read error and a write error valid in the same cycle capture the write error: its ID, its flags, RDWR = 1 and the write's address.
- R6: Type word layout: master ID in bits 20:8, RDWR in bit 4 (0 = read error, 1 = write error), ECC double-bit error in bit 3, restricted-bank access in bit 2, ROM write in bit 0. Every other bit reads 0.
- R7: Register writes to index 1 (type) and index 2 (address) have no effect on the stored values. Index 3 always reads 0.
- R8: An error event in the same cycle as a clearing write to the status bit is captured, and the status bit stays 1.
- R9: `errIrq` is high exactly when the status bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdErrValid | input | 1 | Read-access error event this cycle |
| rdErrId | input | 13 | Master ID of the failing read |
| rdErrAddr | input | 32 | Address of the failing read |
| rdErrEcc | input | 1 | Read hit an ECC double-bit error |
| rdErrBank | input | 1 | Read targeted a restricted bank |
| rdErrRom | input | 1 | ROM-region cause flag for the read event |
| wrErrValid | input | 1 | Write-access error event this cycle |
| wrErrId | input | 13 | Master ID of the failing write |
| wrErrAddr | input | 32 | Address of the failing write |
| wrErrEcc | input | 1 | Write hit an ECC double-bit error |
| wrErrBank | input | 1 | Write targeted a restricted bank |
| wrErrRom | input | 1 | Write went into a ROM region |
| regIdx | input | 2 | Register word index (0 status, 1 type, 2 address) |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regIdx` |
| errIrq | output | 1 | Level error interrupt |

## Verification
The bound checker watches on every cycle that the capture registers stay frozen while the status bit is set, and that a clear arms capture again. It also checks that a write error wins over a simultaneous read error in both words, that the reserved type bits stay zero, and that a capture raises the interrupt one edge later. The directed scenarios show what the ports alone can show: the exact field positions of a read-back type word, the ignored writes to the type and address words, the zero read of the spare index, a write of zero to the status bit, and a new error that coincides with a clear and keeps the status set.

// File: rtl/errCapturePkg.sv
package errCapturePkg;

  // Register word indices seen by software.
  localparam int unsigned IDX_STATUS = 0;
  localparam int unsigned IDX_TYPE   = 1;
  localparam int unsigned IDX_ADDR   = 2;

  // Bit positions inside the error-type word.
  localparam int unsigned POS_ROM    = 0;
  localparam int unsigned POS_BANK   = 2;
  localparam int unsigned POS_ECC    = 3;
  localparam int unsigned POS_RDWR   = 4;
  localparam int unsigned POS_ID     = 8;

  // Strobes sent from the control to the datapath.
  typedef struct packed {
    logic load;       // load type and address registers this edge
    logic takeWrite;  // choose the write event over the read event
    logic setStatus;  // status bit becomes 1
    logic clearStatus;// status bit becomes 0
  } capStrobes_t;

endpackage

// File: rtl/errCaptureCtrl.sv
module errCaptureCtrl
  import errCapturePkg::*;
#(
  parameter int unsigned IDX_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rdErrValid,
  input  logic             wrErrValid,
  input  logic [IDX_W-1:0] regIdx,
  input  logic             regWrEn,
  input  logic             wrBitZero,
  output capStrobes_t      strobes,
  output logic             statusQ
);

  logic anyErr;
  logic clearReq;
  logic armed;

  assign anyErr   = rdErrValid | wrErrValid;
  assign clearReq = regWrEn && (regIdx == IDX_W'(IDX_STATUS)) && wrBitZero;
  // Capture is armed while the flag is clear, or in the cycle it is cleared.
  assign armed    = !statusQ || clearReq;

  always_comb begin
    strobes             = '0;
    strobes.load        = anyErr && armed;
    strobes.takeWrite   = wrErrValid;
    strobes.setStatus   = anyErr && armed;
    strobes.clearStatus = clearReq && !(anyErr && armed);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= 1'b0;
    end else if (strobes.setStatus) begin
      statusQ <= 1'b1;
    end else if (strobes.clearStatus) begin
      statusQ <= 1'b0;
    end
  end

endmodule

// File: rtl/errCaptureData.sv
module errCaptureData
  import errCapturePkg::*;
#(
  parameter int unsigned ID_W   = 13,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  capStrobes_t       strobes,
  input  logic              statusQ,
  input  logic [ID_W-1:0]   rdErrId,
  input  logic [ADDR_W-1:0] rdErrAddr,
  input  logic              rdErrEcc,
  input  logic              rdErrBank,
  input  logic              rdErrRom,
  input  logic [ID_W-1:0]   wrErrId,
  input  logic [ADDR_W-1:0] wrErrAddr,
  input  logic              wrErrEcc,
  input  logic              wrErrBank,
  input  logic              wrErrRom,
  input  logic [IDX_W-1:0]  regIdx,
  output logic [DATA_W-1:0] typeQ,
  output logic [DATA_W-1:0] addrQ,
  output logic [DATA_W-1:0] regRdData
);

  localparam int unsigned ID_TOP = POS_ID + ID_W;

  logic [ID_W-1:0]   selId;
  logic [ADDR_W-1:0] selAddr;
  logic              selEcc;
  logic              selBank;
  logic              selRom;
  logic [DATA_W-1:0] typeNext;
  logic [DATA_W-1:0] addrNext;

  // Pick one event: a write wins over a simultaneous read.
  always_comb begin
    if (strobes.takeWrite) begin
      selId   = wrErrId;
      selAddr = wrErrAddr;
      selEcc  = wrErrEcc;
      selBank = wrErrBank;
      selRom  = wrErrRom;
    end else begin
      selId   = rdErrId;
      selAddr = rdErrAddr;
      selEcc  = rdErrEcc;
      selBank = rdErrBank;
      selRom  = rdErrRom;
    end
  end

  // Assemble the type word; unlisted bits stay zero.
  always_comb begin
    typeNext                   = '0;
    typeNext[ID_TOP-1:POS_ID]  = selId;
    typeNext[POS_RDWR]         = strobes.takeWrite;
    typeNext[POS_ECC]          = selEcc;
    typeNext[POS_BANK]         = selBank;
    typeNext[POS_ROM]          = selRom;
  end

  // The address is widened to the register width.
  generate
    if (ADDR_W < DATA_W) begin : g_addrPad
      assign addrNext = {{(DATA_W-ADDR_W){1'b0}}, selAddr};
    end else begin : g_addrFull
      assign addrNext = selAddr[DATA_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      typeQ <= '0;
      addrQ <= '0;
    end else if (strobes.load) begin
      typeQ <= typeNext;
      addrQ <= addrNext;
    end
  end

  // Read mux; unused indices return zero.
  always_comb begin
    regRdData = '0;
    case (regIdx)
      IDX_W'(IDX_STATUS): regRdData[0] = statusQ;
      IDX_W'(IDX_TYPE):   regRdData    = typeQ;
      IDX_W'(IDX_ADDR):   regRdData    = addrQ;
      default:            regRdData    = '0;
    endcase
  end

endmodule

// File: rtl/errCaptureReg.sv
module errCaptureReg
  import errCapturePkg::*;
#(
  parameter int unsigned ID_W   = 13,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdErrValid,
  input  logic [ID_W-1:0]   rdErrId,
  input  logic [ADDR_W-1:0] rdErrAddr,
  input  logic              rdErrEcc,
  input  logic              rdErrBank,
  input  logic              rdErrRom,
  input  logic              wrErrValid,
  input  logic [ID_W-1:0]   wrErrId,
  input  logic [ADDR_W-1:0] wrErrAddr,
  input  logic              wrErrEcc,
  input  logic              wrErrBank,
  input  logic              wrErrRom,
  input  logic [IDX_W-1:0]  regIdx,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              errIrq
);

  capStrobes_t       strobes;
  logic              statusQ;
  logic [DATA_W-1:0] typeQ;
  logic [DATA_W-1:0] addrQ;
  logic              unusedWrBits;

  // Only bit 0 of a register write carries meaning.
  assign unusedWrBits = ^regWrData[DATA_W-1:1];

  errCaptureCtrl #(.IDX_W(IDX_W)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .rdErrValid (rdErrValid),
    .wrErrValid (wrErrValid),
    .regIdx     (regIdx),
    .regWrEn    (regWrEn),
    .wrBitZero  (regWrData[0]),
    .strobes    (strobes),
    .statusQ    (statusQ)
  );

  errCaptureData #(
    .ID_W   (ID_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
  ) i_data (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .statusQ   (statusQ),
    .rdErrId   (rdErrId),
    .rdErrAddr (rdErrAddr),
    .rdErrEcc  (rdErrEcc),
    .rdErrBank (rdErrBank),
    .rdErrRom  (rdErrRom),
    .wrErrId   (wrErrId),
    .wrErrAddr (wrErrAddr),
    .wrErrEcc  (wrErrEcc),
    .wrErrBank (wrErrBank),
    .wrErrRom  (wrErrRom),
    .regIdx    (regIdx),
    .typeQ     (typeQ),
    .addrQ     (addrQ),
    .regRdData (regRdData)
  );

  assign errIrq = statusQ;

endmodule

// File: rtl/errCaptureChk.sv
module errCaptureChk #(
  parameter int unsigned ID_W   = 13,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdErrValid,
  input logic              wrErrValid,
  input logic [ADDR_W-1:0] wrErrAddr,
  input logic [IDX_W-1:0]  regIdx,
  input logic              regWrEn,
  input logic [DATA_W-1:0] regWrData,
  input logic              statusQ,
  input logic [DATA_W-1:0] typeQ,
  input logic [DATA_W-1:0] addrQ,
  input logic              errIrq
);

  localparam logic [DATA_W-1:0] ID_MASK   = DATA_W'(((1 << ID_W) - 1) << 8);
  localparam logic [DATA_W-1:0] USED_MASK = ID_MASK | DATA_W'(32'h1D);

  logic anyErr;
  logic clearReq;
  logic zeroWrite;

  assign anyErr    = rdErrValid | wrErrValid;
  assign clearReq  = regWrEn && (regIdx == '0) && regWrData[0];
  assign zeroWrite = regWrEn && (regIdx == '0) && !regWrData[0];

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> (!errIrq && typeQ == '0 && addrQ == '0));

  assert_capture_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!statusQ && anyErr) |=> (statusQ && errIrq));

  assert_frozen_R3: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ && !clearReq) |=> ($stable(typeQ) && $stable(addrQ) && statusQ));

  assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ && clearReq && !anyErr) |=> !statusQ);

  assert_zero_write_keeps_R4: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ && zeroWrite) |=> statusQ);

  assert_write_wins_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!statusQ && rdErrValid && wrErrValid) |=>
      (typeQ[4] && addrQ == DATA_W'($past(wrErrAddr))));

  assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((typeQ & ~USED_MASK) == '0));

  assert_clear_with_error_R8: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ && clearReq && anyErr) |=> statusQ);

  assert_irq_level_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!statusQ && !anyErr) |=> !errIrq);

endmodule

bind errCaptureReg errCaptureChk #(
  .ID_W   (ID_W),
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .IDX_W  (IDX_W)
) i_errCaptureChk (
  .clk        (clk),
  .rstN       (rstN),
  .rdErrValid (rdErrValid),
  .wrErrValid (wrErrValid),
  .wrErrAddr  (wrErrAddr),
  .regIdx     (regIdx),
  .regWrEn    (regWrEn),
  .regWrData  (regWrData),
  .statusQ    (statusQ),
  .typeQ      (typeQ),
  .addrQ      (addrQ),
  .errIrq     (errIrq)
);

// File: tb/test_errCaptureReg.sv
module test_errCaptureReg;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rdErrValid = 1'b0;
  logic [12:0] rdErrId = '0;
  logic [31:0] rdErrAddr = '0;
  logic        rdErrEcc = 1'b0, rdErrBank = 1'b0, rdErrRom = 1'b0;
  logic        wrErrValid = 1'b0;
  logic [12:0] wrErrId = '0;
  logic [31:0] wrErrAddr = '0;
  logic        wrErrEcc = 1'b0, wrErrBank = 1'b0, wrErrRom = 1'b0;
  logic [1:0]  regIdx = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        errIrq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  errCaptureReg i_errCaptureReg (
    .clk(clk), .rstN(rstN),
    .rdErrValid(rdErrValid), .rdErrId(rdErrId), .rdErrAddr(rdErrAddr),
    .rdErrEcc(rdErrEcc), .rdErrBank(rdErrBank), .rdErrRom(rdErrRom),
    .wrErrValid(wrErrValid), .wrErrId(wrErrId), .wrErrAddr(wrErrAddr),
    .wrErrEcc(wrErrEcc), .wrErrBank(wrErrBank), .wrErrRom(wrErrRom),
    .regIdx(regIdx), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .errIrq(errIrq)
  );

  function automatic logic [31:0] typeWord(logic [12:0] id, logic wr,
                                           logic ecc, logic bank, logic rom);
    return (32'(id) << 8) | (32'(wr) << 4) | (32'(ecc) << 3)
         | (32'(bank) << 2) | 32'(rom);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic readReg(logic [1:0] idx, output logic [31:0] val);
    regIdx = idx;
    #1;
    val = regRdData;
  endtask

  task automatic writeReg(logic [1:0] idx, logic [31:0] data);
    regIdx = idx; regWrData = data; regWrEn = 1'b1;
    tick();
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic setRead(logic [12:0] id, logic [31:0] a, logic e, logic b, logic r);
    rdErrValid = 1'b1; rdErrId = id; rdErrAddr = a;
    rdErrEcc = e; rdErrBank = b; rdErrRom = r;
  endtask

  task automatic setWrite(logic [12:0] id, logic [31:0] a, logic e, logic b, logic r);
    wrErrValid = 1'b1; wrErrId = id; wrErrAddr = a;
    wrErrEcc = e; wrErrBank = b; wrErrRom = r;
  endtask

  task automatic dropEvents();
    rdErrValid = 1'b0; wrErrValid = 1'b0;
    rdErrId = '0; wrErrId = '0; rdErrAddr = '0; wrErrAddr = '0;
    {rdErrEcc, rdErrBank, rdErrRom, wrErrEcc, wrErrBank, wrErrRom} = '0;
  endtask

  task automatic testReset();
    logic [31:0] v;
    readReg(2'd0, v); check("R1 status", v, 32'd0);
    readReg(2'd1, v); check("R1 type", v, 32'd0);
    readReg(2'd2, v); check("R1 addr", v, 32'd0);
    check("R1 irq", 32'(errIrq), 32'd0);
  endtask

  task automatic testFirstRead();
    logic [31:0] v;
    setRead(13'h1ABC, 32'hDEAD_0040, 1'b1, 1'b0, 1'b0);
    readReg(2'd0, v); check("R2 status before edge", v, 32'd0);
    tick();
    dropEvents();
    readReg(2'd0, v); check("R2 status after capture", v, 32'd1);
    check("R9 irq follows status", 32'(errIrq), 32'd1);
    readReg(2'd1, v); check("R6 read-error type word", v, typeWord(13'h1ABC, 1'b0, 1'b1, 1'b0, 1'b0));
    readReg(2'd2, v); check("R2 address", v, 32'hDEAD_0040);
  endtask

  task automatic testFreeze();
    logic [31:0] v;
    setWrite(13'h0055, 32'h1111_2222, 1'b0, 1'b1, 1'b1);
    tick();
    setRead(13'h0777, 32'h3333_4444, 1'b1, 1'b1, 1'b0);
    tick();
    dropEvents();
    readReg(2'd1, v); check("R3 type frozen", v, typeWord(13'h1ABC, 1'b0, 1'b1, 1'b0, 1'b0));
    readReg(2'd2, v); check("R3 addr frozen", v, 32'hDEAD_0040);
  endtask

  task automatic testIgnoredWrites();
    logic [31:0] v;
    writeReg(2'd1, 32'hFFFF_FFFF);
    writeReg(2'd2, 32'h0123_4567);
    writeReg(2'd3, 32'hFFFF_FFFF);
    readReg(2'd1, v); check("R7 type write ignored", v, typeWord(13'h1ABC, 1'b0, 1'b1, 1'b0, 1'b0));
    readReg(2'd2, v); check("R7 addr write ignored", v, 32'hDEAD_0040);
    readReg(2'd3, v); check("R7 spare index zero", v, 32'd0);
    readReg(2'd0, v); check("R7 status untouched", v, 32'd1);
  endtask

  task automatic testClear();
    logic [31:0] v;
    writeReg(2'd0, 32'hFFFF_FFFE);
    readReg(2'd0, v); check("R4 zero write keeps status", v, 32'd1);
    writeReg(2'd0, 32'h0000_0001);
    readReg(2'd0, v); check("R4 w1c clears status", v, 32'd0);
    check("R9 irq low after clear", 32'(errIrq), 32'd0);
  endtask

  task automatic testSimultaneous();
    logic [31:0] v;
    setRead(13'h0AAA, 32'h0000_1000, 1'b1, 1'b0, 1'b0);
    setWrite(13'h1555, 32'h8000_2000, 1'b0, 1'b1, 1'b1);
    tick();
    dropEvents();
    readReg(2'd1, v); check("R5 write wins type", v, typeWord(13'h1555, 1'b1, 1'b0, 1'b1, 1'b1));
    readReg(2'd2, v); check("R5 write wins addr", v, 32'h8000_2000);
    readReg(2'd0, v); check("R2 status set by pair", v, 32'd1);
  endtask

  task automatic testClearWithError();
    logic [31:0] v;
    setRead(13'h0F0F, 32'h4000_0004, 1'b0, 1'b1, 1'b0);
    writeReg(2'd0, 32'h1);
    dropEvents();
    readReg(2'd0, v); check("R8 status stays set", v, 32'd1);
    check("R8 irq stays high", 32'(errIrq), 32'd1);
    readReg(2'd1, v); check("R8 new type captured", v, typeWord(13'h0F0F, 1'b0, 1'b0, 1'b1, 1'b0));
    readReg(2'd2, v); check("R8 new addr captured", v, 32'h4000_0004);
  endtask

  task automatic testFieldEdges();
    logic [31:0] v;
    writeReg(2'd0, 32'h1);
    setWrite(13'h1FFF, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b1);
    tick();
    dropEvents();
    readReg(2'd1, v); check("R6 all fields set", v, 32'h001F_FF1D);
    writeReg(2'd0, 32'h1);
    setWrite(13'h0001, 32'h0, 1'b0, 1'b0, 1'b1);
    tick();
    dropEvents();
    readReg(2'd1, v); check("R6 rom flag bit0 id bit8", v, 32'h0000_0111);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    tick();
    testReset();
    testFirstRead();
    testFreeze();
    testIgnoredWrites();
    testClear();
    testSimultaneous();
    testClearWithError();
    testFieldEdges();
    tick();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule